// File: doc/BRIEF.md
# Unified Issue and Reorder Buffer

This block is the scheduling core of a small out-of-order processor. It keeps every in-flight instruction in one circular buffer. Each slot renames the instruction's sources, holds its operands until they are available, selects it for execution, collects its result and finally retires it. No separate reservation station sits beside it. Each slot holds the per-instruction state apart from the register file contents: operand tags and values, destination, result and fault flag. Slots are retired strictly in program order, so a faulting instruction traps precisely.

Instructions enter in program order through the dispatch port. Each one takes the slot at the tail, and that slot number is its tag. Source operands carry the current register file values. An alias table records, for each architectural register, the youngest in-flight writer. A source with a pending writer waits on that writer's tag. A source whose writer already has a result takes that result. A source with no writer uses the supplied register file value.

The execution units return results on a single writeback bus. That bus completes the producing slot and wakes every slot waiting on its tag. The oldest ready slot is issued, one per cycle. A memory write issues only from the head slot. The commit port retires the head slot when its result is present. A faulting head raises a trap and empties the buffer. An external flush also empties the buffer.

Each slot runs its own state machine:
- FREE goes to WAIT (alloc, a source is pending) or to READY (alloc, both sources known).
- WAIT goes to READY (wakeup, the last pending source is captured).
- READY goes to EXEC (grant).
- EXEC goes to RETIRE (own writeback).
- RETIRE goes to FREE (retire_ack).
- Any state goes to FREE (clear, on flush or trap).

Top module: `iurob_top`

## Requirements
- R1: After reset the buffer is empty: disp_ready is 1, and iss_valid, cm_valid and trap_valid are 0.
- R2: A dispatch is accepted when disp_valid and disp_ready are both 1. The instruction takes the slot numbered disp_tag, and tags advance by one modulo DEPTH in program order. disp_ready is 0 exactly when DEPTH slots are occupied. A dispatch offered while disp_ready is 0 is ignored.
- R3: Each source operand is resolved at dispatch. If a pending writer of that register exists, the operand waits on the tag of the youngest such writer. If that writer has already written back, the operand takes the writer's result. If no in-flight non-store slot writes that register, the operand takes disp_src1_val or disp_src2_val. A store never acts as a writer.
- R4: A writeback to an executing slot delivers wb_val to every waiting operand whose tag matches. This includes an operand being dispatched in that same cycle. A slot whose last operand arrives in cycle t can issue from cycle t+1.
- R5: Each cycle at most one slot issues: the oldest slot in READY that is eligible. iss_op1 and iss_op2 carry its operands. A slot dispatched with both operands known can issue in the next cycle.
- R6: A store (disp_is_store = 1) issues only while its slot is the head. It never updates the alias table.
- R7: A writeback moves a slot from EXEC to RETIRE, recording wb_val and wb_exc. A writeback whose tag names a slot that is not in EXEC has no effect.
- R8: The head slot commits when it is in RETIRE without a fault. cm_valid, cm_dst, cm_val and cm_is_store describe it in that cycle, at most one commit occurs per cycle, and commits follow dispatch order.
- R9: When the head slot is in RETIRE with a fault, trap_valid is 1 and trap_tag is the head tag. No commit, issue or dispatch takes effect in that cycle, and from the next cycle every slot is free.
- R10: While flush is 1, no commit, trap, issue or dispatch takes effect, and from the next cycle every slot is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard every in-flight instruction |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | A slot is free |
| disp_is_store | input | 1 | Instruction is a memory write |
| disp_dst | input | AREG_W | Destination register |
| disp_src1 | input | AREG_W | First source register |
| disp_src1_val | input | DATA_W | Register file value of first source |
| disp_src2 | input | AREG_W | Second source register |
| disp_src2_val | input | DATA_W | Register file value of second source |
| disp_tag | output | TAG_W | Tag given to the dispatched instruction |
| iss_valid | output | 1 | An instruction is issued |
| iss_tag | output | TAG_W | Tag of the issued instruction |
| iss_op1 | output | DATA_W | First operand |
| iss_op2 | output | DATA_W | Second operand |
| iss_is_store | output | 1 | Issued instruction is a store |
| wb_valid | input | 1 | Result broadcast |
| wb_tag | input | TAG_W | Tag of the finishing instruction |
| wb_val | input | DATA_W | Result value |
| wb_exc | input | 1 | Instruction faulted |
| cm_valid | output | 1 | Head instruction retires |
| cm_is_store | output | 1 | Retiring instruction is a store |
| cm_dst | output | AREG_W | Destination of the retiring instruction |
| cm_val | output | DATA_W | Result of the retiring instruction |
| trap_valid | output | 1 | Head instruction faulted |
| trap_tag | output | TAG_W | Tag of the faulting instruction |

## Verification
The delicate overlap is a writeback that falls in the same cycle as the dispatch of an instruction reading that result. A second overlap is a commit that falls in the same cycle as a dispatch that renames the committing register. The bench provokes both by dispatching on most cycles with only eight registers in use, so dependencies are dense. It also returns results with latencies of one to several cycles. Every cycle the bench's queue model resolves the new operands from its own program-ordered list. It compares the issued operands and the committed values against the design, so a missed bypass appears as a wrong iss_op or cm_val.

// File: rtl/iurob_pkg.sv
`timescale 1ns/1ps
package iurob_pkg;
    parameter int DEPTH  = 8;    // slot count, power of two
    parameter int DATA_W = 32;
    parameter int AREG_W = 5;

    localparam int TAG_W    = $clog2(DEPTH);
    localparam int CNT_W    = TAG_W + 1;
    localparam int NUM_AREG = 1 << AREG_W;

    typedef enum logic [2:0] {
        ST_FREE,
        ST_WAIT,
        ST_READY,
        ST_EXEC,
        ST_RETIRE
    } ent_state_t;

    typedef struct packed {
        logic              rdy;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] val;
    } opnd_t;

    typedef struct packed {
        logic              is_store;
        logic [AREG_W-1:0] dst;
        opnd_t             a;
        opnd_t             b;
    } slot_info_t;
endpackage

// File: rtl/iurob_alias.sv
`timescale 1ns/1ps
module iurob_alias
    import iurob_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              set_en,
    input  logic [AREG_W-1:0] set_areg,
    input  logic [TAG_W-1:0]  set_tag,
    input  logic              drop_en,
    input  logic [AREG_W-1:0] drop_areg,
    input  logic [TAG_W-1:0]  drop_tag,
    input  logic [AREG_W-1:0] look_a,
    input  logic [AREG_W-1:0] look_b,
    output logic              a_hit,
    output logic [TAG_W-1:0]  a_tag,
    output logic              b_hit,
    output logic [TAG_W-1:0]  b_tag
);
    logic [NUM_AREG-1:0] live;
    logic [TAG_W-1:0]    owner [NUM_AREG];

    // a newer writer always wins over the retiring one
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            live <= '0;
        end else begin
            if (drop_en && live[drop_areg] && owner[drop_areg] == drop_tag)
                live[drop_areg] <= 1'b0;
            if (set_en)
                live[set_areg] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (set_en)
            owner[set_areg] <= set_tag;
    end

    always_comb begin
        a_hit = live[look_a];
        a_tag = owner[look_a];
        b_hit = live[look_b];
        b_tag = owner[look_b];
    end
endmodule

// File: rtl/iurob_pick.sv
`timescale 1ns/1ps
module iurob_pick
    import iurob_pkg::*;
(
    input  logic [DEPTH-1:0] ready_vec,
    input  logic [DEPTH-1:0] store_vec,
    input  logic [TAG_W-1:0] head,
    output logic             pick_valid,
    output logic [TAG_W-1:0] pick_tag
);
    logic [TAG_W-1:0] idx;

    // walk from the head so the first hit is the oldest
    always_comb begin
        pick_valid = 1'b0;
        pick_tag   = head;
        idx        = head;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + TAG_W'(k);
            if (!pick_valid && ready_vec[idx] && (!store_vec[idx] || k == 0)) begin
                pick_valid = 1'b1;
                pick_tag   = idx;
            end
        end
    end
endmodule

// File: rtl/iurob_slot.sv
`timescale 1ns/1ps
module iurob_slot
    import iurob_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              alloc,
    input  slot_info_t        alloc_info,
    input  logic              wb_live,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_val,
    input  logic              wb_exc,
    input  logic              grant,
    input  logic              retire_ack,
    output ent_state_t        state,
    output slot_info_t        info,
    output logic [DATA_W-1:0] result,
    output logic              fault
);
    localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(IDX);

    ent_state_t state_n;
    logic       own_wb, a_hit, b_hit;

    always_comb begin
        own_wb = wb_live && (wb_tag == MY_TAG) && (state == ST_EXEC);
        a_hit  = wb_live && !info.a.rdy && (info.a.tag == wb_tag);
        b_hit  = wb_live && !info.b.rdy && (info.b.tag == wb_tag);
    end

    always_comb begin
        state_n = state;
        if (clr) begin
            state_n = ST_FREE;
        end else begin
            unique case (state)
                ST_FREE:   if (alloc)
                               state_n = (alloc_info.a.rdy && alloc_info.b.rdy) ? ST_READY : ST_WAIT;
                ST_WAIT:   if ((info.a.rdy || a_hit) && (info.b.rdy || b_hit))
                               state_n = ST_READY;
                ST_READY:  if (grant)      state_n = ST_EXEC;
                ST_EXEC:   if (own_wb)     state_n = ST_RETIRE;
                ST_RETIRE: if (retire_ack) state_n = ST_FREE;
                default:   state_n = ST_FREE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FREE;
        else        state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            info   <= '0;
            result <= '0;
            fault  <= 1'b0;
        end else if (alloc && state == ST_FREE && !clr) begin
            info  <= alloc_info;
            fault <= 1'b0;
        end else begin
            if (state == ST_WAIT) begin
                if (a_hit) begin
                    info.a.rdy <= 1'b1;
                    info.a.val <= wb_val;
                end
                if (b_hit) begin
                    info.b.rdy <= 1'b1;
                    info.b.val <= wb_val;
                end
            end
            if (own_wb) begin
                result <= wb_val;
                fault  <= wb_exc;
            end
        end
    end

    AST_RETIRE_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RETIRE && $past(state) != ST_RETIRE) |-> $past(wb_live && wb_tag == MY_TAG)); // R7
endmodule

// File: rtl/iurob_top.sv
`timescale 1ns/1ps
module iurob_top
    import iurob_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              disp_valid,
    output logic              disp_ready,
    input  logic              disp_is_store,
    input  logic [AREG_W-1:0] disp_dst,
    input  logic [AREG_W-1:0] disp_src1,
    input  logic [DATA_W-1:0] disp_src1_val,
    input  logic [AREG_W-1:0] disp_src2,
    input  logic [DATA_W-1:0] disp_src2_val,
    output logic [TAG_W-1:0]  disp_tag,
    output logic              iss_valid,
    output logic [TAG_W-1:0]  iss_tag,
    output logic [DATA_W-1:0] iss_op1,
    output logic [DATA_W-1:0] iss_op2,
    output logic              iss_is_store,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_val,
    input  logic              wb_exc,
    output logic              cm_valid,
    output logic              cm_is_store,
    output logic [AREG_W-1:0] cm_dst,
    output logic [DATA_W-1:0] cm_val,
    output logic              trap_valid,
    output logic [TAG_W-1:0]  trap_tag
);
    logic [TAG_W-1:0]  head, tail;
    logic [CNT_W-1:0]  count;
    ent_state_t        st  [DEPTH];
    slot_info_t        inf [DEPTH];
    logic [DATA_W-1:0] res [DEPTH];
    logic [DEPTH-1:0]  flt, ready_vec, store_vec;
    logic              disp_fire, commit_fire, trap_fire, clr_all, wb_live, head_ret;
    logic              pick_valid, a_hit, b_hit;
    logic [TAG_W-1:0]  pick_tag, a_tag, b_tag;
    slot_info_t        new_info;

    function automatic opnd_t resolve_src(
        input logic              hit,
        input logic [TAG_W-1:0]  ptag,
        input logic [DATA_W-1:0] rf_val,
        input ent_state_t        pst,
        input logic [DATA_W-1:0] pres,
        input logic              live,
        input logic [TAG_W-1:0]  wtag,
        input logic [DATA_W-1:0] wval
    );
        opnd_t o;
        o.rdy = 1'b1;
        o.tag = ptag;
        o.val = rf_val;
        if (hit) begin
            if (pst == ST_RETIRE)           o.val = pres;
            else if (live && wtag == ptag)  o.val = wval;
            else begin
                o.rdy = 1'b0;
                o.val = '0;
            end
        end
        return o;
    endfunction

    always_comb begin
        head_ret    = (st[head] == ST_RETIRE);
        commit_fire = !flush && head_ret && !flt[head];
        trap_fire   = !flush && head_ret &&  flt[head];
        clr_all     = flush || trap_fire;
        disp_ready  = (count != CNT_W'(DEPTH));
        disp_fire   = disp_valid && disp_ready && !clr_all;
        wb_live     = wb_valid && (st[wb_tag] == ST_EXEC);
        new_info.is_store = disp_is_store;
        new_info.dst      = disp_dst;
        new_info.a = resolve_src(a_hit, a_tag, disp_src1_val, st[a_tag], res[a_tag], wb_live, wb_tag, wb_val);
        new_info.b = resolve_src(b_hit, b_tag, disp_src2_val, st[b_tag], res[b_tag], wb_live, wb_tag, wb_val);
    end

    iurob_alias u_alias (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_all),
        .set_en   (disp_fire && !disp_is_store),
        .set_areg (disp_dst),
        .set_tag  (tail),
        .drop_en  (commit_fire && !inf[head].is_store),
        .drop_areg(inf[head].dst),
        .drop_tag (head),
        .look_a   (disp_src1),
        .look_b   (disp_src2),
        .a_hit    (a_hit),
        .a_tag    (a_tag),
        .b_hit    (b_hit),
        .b_tag    (b_tag)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign ready_vec[g] = (st[g] == ST_READY);
        assign store_vec[g] = inf[g].is_store;

        iurob_slot #(.IDX(g)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr_all),
            .alloc     (disp_fire && tail == TAG_W'(g)),
            .alloc_info(new_info),
            .wb_live   (wb_live),
            .wb_tag    (wb_tag),
            .wb_val    (wb_val),
            .wb_exc    (wb_exc),
            .grant     (iss_valid && iss_tag == TAG_W'(g)),
            .retire_ack(commit_fire && head == TAG_W'(g)),
            .state     (st[g]),
            .info      (inf[g]),
            .result    (res[g]),
            .fault     (flt[g])
        );
    end

    iurob_pick u_pick (
        .ready_vec (ready_vec),
        .store_vec (store_vec),
        .head      (head),
        .pick_valid(pick_valid),
        .pick_tag  (pick_tag)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (disp_fire)   tail <= tail + 1'b1;
            if (commit_fire) head <= head + 1'b1;
            count <= count + CNT_W'(disp_fire) - CNT_W'(commit_fire);
        end
    end

    always_comb begin
        disp_tag     = tail;
        iss_valid    = pick_valid && !clr_all;
        iss_tag      = pick_tag;
        iss_op1      = inf[pick_tag].a.val;
        iss_op2      = inf[pick_tag].b.val;
        iss_is_store = inf[pick_tag].is_store;
        cm_valid     = commit_fire;
        cm_is_store  = inf[head].is_store;
        cm_dst       = inf[head].dst;
        cm_val       = res[head];
        trap_valid   = trap_fire;
        trap_tag     = head;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R2
    AST_PICK_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n || clr_all)
        (|(ready_vec & ~store_vec)) |-> iss_valid); // R5
    AST_STORE_AT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_is_store) |-> (iss_tag == head)); // R6
    AST_TRAP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> (disp_ready && !cm_valid && !iss_valid && !trap_valid)); // R9
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (disp_ready && !cm_valid && !iss_valid && !trap_valid)); // R10
endmodule

// File: tb/tb_iurob_top.sv
`timescale 1ns/1ps
module tb_iurob_top;
    import iurob_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic              rst_n, flush, disp_valid, disp_ready, disp_is_store;
    logic [AREG_W-1:0] disp_dst, disp_src1, disp_src2, cm_dst;
    logic [DATA_W-1:0] disp_src1_val, disp_src2_val, iss_op1, iss_op2, wb_val, cm_val;
    logic [TAG_W-1:0]  disp_tag, iss_tag, wb_tag, trap_tag;
    logic              iss_valid, iss_is_store, wb_valid, wb_exc, cm_valid, cm_is_store, trap_valid;

    iurob_top dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_is_store(disp_is_store),
        .disp_dst(disp_dst), .disp_src1(disp_src1), .disp_src1_val(disp_src1_val),
        .disp_src2(disp_src2), .disp_src2_val(disp_src2_val), .disp_tag(disp_tag),
        .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_op1(iss_op1), .iss_op2(iss_op2),
        .iss_is_store(iss_is_store), .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_val(wb_val),
        .wb_exc(wb_exc), .cm_valid(cm_valid), .cm_is_store(cm_is_store), .cm_dst(cm_dst),
        .cm_val(cm_val), .trap_valid(trap_valid), .trap_tag(trap_tag)
    );

    // program-ordered model record; st: 1 wait, 2 ready, 3 exec, 4 retire
    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic              is_st;
        logic [AREG_W-1:0] dst;
        logic [2:0]        st;
        logic              r1;
        logic [TAG_W-1:0]  t1;
        logic [DATA_W-1:0] v1;
        logic              r2;
        logic [TAG_W-1:0]  t2;
        logic [DATA_W-1:0] v2;
        logic [DATA_W-1:0] res;
        logic              exc;
        logic              woke;
    } mrec_t;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [31:0]       due;
        logic [DATA_W-1:0] val;
        logic              exc;
    } pend_t;

    mrec_t             q[$];
    pend_t             pend[$];
    logic [DATA_W-1:0] rf [NUM_AREG];
    logic              exc_tab [DEPTH];
    int                m_head, m_tail, checks, fails;
    logic              flush_prev, stray_prev, stray_now, exc_nxt, done;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic resolve(input logic [AREG_W-1:0] src, input logic [DATA_W-1:0] rfv,
                           input logic live, output logic r, output logic [TAG_W-1:0] t,
                           output logic [DATA_W-1:0] v, output logic w);
        r = 1'b1; t = '0; v = rfv; w = 1'b0;
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (!q[i].is_st && q[i].dst == src) begin
                t = q[i].tag;
                if (q[i].st == 3'd4) v = q[i].res;
                else if (live && wb_tag == q[i].tag && q[i].st == 3'd3) begin
                    v = wb_val; w = 1'b1;
                end else begin
                    r = 1'b0; v = '0;
                end
                break;
            end
        end
    endtask

    initial begin
        done = 1'b0;
        #(64'd1600000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd11));
        checks = 0; fails = 0; m_head = 0; m_tail = 0;
        flush_prev = 1'b0; stray_prev = 1'b0;
        rst_n = 1'b0; flush = 1'b0; disp_valid = 1'b0; disp_is_store = 1'b0;
        disp_dst = '0; disp_src1 = '0; disp_src2 = '0; disp_src1_val = '0; disp_src2_val = '0;
        wb_valid = 1'b0; wb_tag = '0; wb_val = '0; wb_exc = 1'b0;
        for (int i = 0; i < NUM_AREG; i++) rf[i] = DATA_W'(i * 17 + 3);
        for (int i = 0; i < DEPTH; i++) exc_tab[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "disp_ready", 64'(disp_ready), 64'd1);
        chk("R1", "iss_valid", 64'(iss_valid), 64'd0);
        chk("R1", "cm_valid", 64'(cm_valid), 64'd0);
        chk("R1", "trap_valid", 64'(trap_valid), 64'd0);

        for (int cyc = 0; cyc < 5000; cyc++) begin
            logic        e_ready, e_trap, e_cm, wlive, fire, nr1, nr2, nw1, nw2;
            logic [TAG_W-1:0]  nt1, nt2;
            logic [DATA_W-1:0] nv1, nv2;
            int          ii, lat, pj;
            string       lab, ilab;
            mrec_t       nrec;

            @(negedge clk);
            // drive this cycle's stimulus
            flush         = ($urandom % 100) < 1;
            disp_valid    = ($urandom % 100) < ((cyc >= 2000 && cyc < 3500) ? 90 : 65);
            disp_is_store = ($urandom % 100) < 15;
            disp_dst      = AREG_W'($urandom % 8);
            disp_src1     = AREG_W'($urandom % 8);
            disp_src2     = AREG_W'($urandom % 8);
            disp_src1_val = rf[disp_src1];
            disp_src2_val = rf[disp_src2];
            exc_nxt       = ($urandom % 100) < 3;
            wb_valid = 1'b0; wb_exc = 1'b0; stray_now = 1'b0;
            pj = -1;
            for (int j = 0; j < pend.size(); j++)
                if (pj < 0 && int'(pend[j].due) <= cyc) pj = j;
            if (pj >= 0) begin
                wb_valid = 1'b1; wb_tag = pend[pj].tag; wb_val = pend[pj].val; wb_exc = pend[pj].exc;
                pend.delete(pj);
            end else if (($urandom % 100) < 10) begin
                logic busy;
                wb_tag = TAG_W'($urandom % DEPTH);
                busy = 1'b0;
                foreach (q[i]) if (q[i].tag == wb_tag && q[i].st == 3'd3) busy = 1'b1;
                if (!busy) begin
                    wb_valid = 1'b1; wb_val = DATA_W'($urandom); wb_exc = 1'b1; stray_now = 1'b1;
                end
            end
            #1;
            // expected outputs for this cycle
            e_ready = q.size() < DEPTH;
            e_trap  = q.size() > 0 && q[0].st == 3'd4 && q[0].exc && !flush;
            e_cm    = q.size() > 0 && q[0].st == 3'd4 && !q[0].exc && !flush;
            ii = -1;
            if (!flush && !e_trap)
                for (int i = 0; i < q.size(); i++)
                    if (ii < 0 && q[i].st == 3'd2 && (!q[i].is_st || i == 0)) ii = i;
            lab = stray_prev ? "R7" : "R8";
            chk(flush_prev ? "R10" : "R2", "disp_ready", 64'(disp_ready), 64'(e_ready));
            if (e_ready) chk("R2", "disp_tag", 64'(disp_tag), 64'(m_tail));
            chk(lab, "cm_valid", 64'(cm_valid), 64'(e_cm));
            chk(flush ? "R10" : "R9", "trap_valid", 64'(trap_valid), 64'(e_trap));
            if (e_trap) chk("R9", "trap_tag", 64'(trap_tag), 64'(m_head));
            if (e_cm) begin
                chk(lab, "cm_val", 64'(cm_val), 64'(q[0].res));
                chk(lab, "cm_is_store", 64'(cm_is_store), 64'(q[0].is_st));
                if (!q[0].is_st) chk(lab, "cm_dst", 64'(cm_dst), 64'(q[0].dst));
            end
            ilab = (ii >= 0 && q[ii].is_st) ? "R6" : "R5";
            chk(flush ? "R10" : ilab, "iss_valid", 64'(iss_valid), 64'(ii >= 0));
            if (ii >= 0) begin
                chk(ilab, "iss_tag", 64'(iss_tag), 64'(q[ii].tag));
                chk(ilab, "iss_is_store", 64'(iss_is_store), 64'(q[ii].is_st));
                chk(q[ii].woke ? "R4" : "R3", "iss_op1", 64'(iss_op1), 64'(q[ii].v1));
                chk(q[ii].woke ? "R4" : "R3", "iss_op2", 64'(iss_op2), 64'(q[ii].v2));
            end
            // advance the model across the coming edge
            wlive = 1'b0;
            foreach (q[i]) if (wb_valid && q[i].tag == wb_tag && q[i].st == 3'd3) wlive = 1'b1;
            if (flush || e_trap) begin
                q.delete(); pend.delete(); m_head = 0; m_tail = 0;
            end else begin
                fire = disp_valid && e_ready;
                resolve(disp_src1, disp_src1_val, wlive, nr1, nt1, nv1, nw1);
                resolve(disp_src2, disp_src2_val, wlive, nr2, nt2, nv2, nw2);
                if (ii >= 0) begin
                    lat = (cyc >= 2000 && cyc < 3500) ? 6 + ($urandom % 6) : 1 + ($urandom % 3);
                    q[ii].st = 3'd3;
                    pend.push_back('{tag: q[ii].tag, due: 32'(cyc + lat),
                                     val: q[ii].v1 + q[ii].v2, exc: exc_tab[q[ii].tag]});
                end
                if (wlive) begin
                    for (int i = 0; i < q.size(); i++) begin
                        if (q[i].tag == wb_tag && q[i].st == 3'd3) begin
                            q[i].st = 3'd4; q[i].res = wb_val; q[i].exc = wb_exc;
                        end else if (q[i].st == 3'd1) begin
                            if (!q[i].r1 && q[i].t1 == wb_tag) begin
                                q[i].r1 = 1'b1; q[i].v1 = wb_val; q[i].woke = 1'b1;
                            end
                            if (!q[i].r2 && q[i].t2 == wb_tag) begin
                                q[i].r2 = 1'b1; q[i].v2 = wb_val; q[i].woke = 1'b1;
                            end
                            if (q[i].r1 && q[i].r2) q[i].st = 3'd2;
                        end
                    end
                end
                if (e_cm) begin
                    if (!q[0].is_st) rf[q[0].dst] = q[0].res;
                    void'(q.pop_front());
                    m_head = (m_head + 1) % DEPTH;
                end
                if (fire) begin
                    nrec.tag = TAG_W'(m_tail); nrec.is_st = disp_is_store; nrec.dst = disp_dst;
                    nrec.st = (nr1 && nr2) ? 3'd2 : 3'd1;
                    nrec.r1 = nr1; nrec.t1 = nt1; nrec.v1 = nv1;
                    nrec.r2 = nr2; nrec.t2 = nt2; nrec.v2 = nv2;
                    nrec.res = '0; nrec.exc = 1'b0; nrec.woke = nw1 || nw2;
                    exc_tab[m_tail] = exc_nxt;
                    q.push_back(nrec);
                    m_tail = (m_tail + 1) % DEPTH;
                end
            end
            flush_prev = flush;
            stray_prev = stray_now;
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule